// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Pair

This block holds the two digital dividers of an integer-N frequency synthesizer. One side divides the crystal reference clock by a ratio R and produces the comparison pulse for a phase detector. The other side divides the VCO clock by N = P·B + A. It models a dual-modulus prescaler with a fixed modulus P (16 or 64, chosen by parameter), a swallow count A and a program count B. A register bank drives R, A and B as steady levels. The block answers with one single-clock pulse per divided period on each side.

Each setting is checked against its legal range. A setting out of range raises an error flag, and the divider keeps running on the last setting that was legal. Legal changes are adopted only at a terminal count, so the period in progress always completes on its old setting. The reference side runs on the reference clock and the main side on the VCO clock. The single active-low reset is synchronous in each domain, and it is expected to arrive already synchronised to both clocks.

Top module: `synth_div_pair`

## Requirements
- R1: For a legal main setting (2 ≤ B ≤ 2047, A < B, A ≤ P−2), `vco_pulse` repeats every exactly P·B + A VCO clocks; the prescaler runs A cycles at modulus P+1 and B−A cycles at modulus P.
- R2: For a legal reference setting (2 ≤ R ≤ 2^R_W − 1), `ref_pulse` repeats every exactly R reference clocks.
- R3: Each pulse on `vco_pulse` and `ref_pulse` is high for exactly one clock of its domain.
- R4: When B < 2, `vco_cfg_err` is high one VCO clock later and the main period stays at its last legal value.
- R5: When A ≥ B or A ≥ P−1, `vco_cfg_err` is high one VCO clock later and the main period stays at its last legal value; with a legal setting the flag is low.
- R6: When R < 2, `ref_cfg_err` is high one reference clock later and the reference period stays at its last legal value.
- R7: A legal new setting written partway through a period takes effect only at that period's terminal count: the period in progress finishes on the old setting, and the following one uses the new one.
- R8: While `rst_n` is low at a clock edge, the pulses and error flags of that domain are cleared at that edge. After release, both dividers start from the parameter defaults (DEF_B, DEF_A, DEF_R).
- R9: The extreme legal settings divide correctly: A = P−2, B = 2, B = 2047, R = 2 and R = 2^R_W − 1.
- R10: With P = 64 and R_W = 12, B = 411 and A = 16 give a main period of 26320 clocks, and R = 256 gives a reference period of 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Crystal reference clock |
| clk_vco | input | 1 | VCO clock to be divided by N |
| rst_n | input | 1 | Synchronous active-low reset, applied in both clock domains |
| ref_div_val | input | R_W | Reference ratio R (R_W is 10 by default, 12 when P = 64) |
| swallow_val | input | 7 | Swallow count A |
| program_val | input | 11 | Program count B |
| ref_pulse | output | 1 | One-clock pulse per R reference clocks |
| ref_cfg_err | output | 1 | High while R is out of range |
| vco_pulse | output | 1 | One-clock pulse per P·B + A VCO clocks |
| vco_cfg_err | output | 1 | High while A or B is out of range |

## Verification
Two functions can fall in the same clock: the terminal-count reload, and the arrival of a new setting, which may be legal or illegal. A new setting is applied just after a pulse, while the next terminal count is still pending. Random legal and illegal settings are also mixed in, so some land as the reload decision is made. Each case is judged by the spacing between consecutive pulses: the first spacing after a change must equal the old ratio exactly, and the next must equal the new ratio or, for an illegal value, the held one, while the error flag follows the legality of the inputs.

// File: rtl/sdp_pkg.sv
`timescale 1ns/1ps
// sdp_pkg: shared widths and the main-divider setting type.
// Assumes: the swallow and program count widths are fixed by the register bank.
package sdp_pkg;
    localparam int A_W     = 7;   // swallow count width
    localparam int B_W     = 11;  // program count width
    localparam int MIN_DIV = 2;   // smallest legal B and R

    typedef struct packed {
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } main_cfg_t;
endpackage

// File: rtl/sdp_cfg_check.sv
`timescale 1ns/1ps
// sdp_cfg_check: decides whether a main-divider setting (A, B) is legal for
// a prescaler of modulus PRESC. Purely combinational.
// Assumes: PRESC - 2 fits in A_W bits.
module sdp_cfg_check
    import sdp_pkg::*;
#(
    parameter int PRESC = 16
) (
    input  main_cfg_t cfg,
    output logic      ok
);
    localparam logic [A_W-1:0] A_MAX = A_W'(PRESC - 2);
    localparam logic [B_W-1:0] B_MIN = B_W'(MIN_DIV);

    // Legality: B at least the minimum, A below B, A at most P-2.
    always_comb begin
        ok = (cfg.b >= B_MIN) && (B_W'(cfg.a) < cfg.b) && (cfg.a <= A_MAX);
    end
endmodule

// File: rtl/sdp_dual_mod_presc.sv
`timescale 1ns/1ps
// sdp_dual_mod_presc: cycle model of a dual-modulus prescaler. It counts down
// and marks the last clock of every prescaler cycle with tc. At tc it reloads
// for a cycle of PRESC+1 clocks (mod_hi = 1) or PRESC clocks (mod_hi = 0).
// Assumes: mod_hi is only meaningful in the clock where tc is high.
module sdp_dual_mod_presc #(
    parameter int PRESC  = 16,
    parameter bit RST_HI = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_hi,
    output logic tc
);
    localparam int            CW    = $clog2(PRESC + 1);
    localparam logic [CW-1:0] LD_HI = CW'(PRESC);
    localparam logic [CW-1:0] LD_LO = CW'(PRESC - 1);

    logic [CW-1:0] cnt;

    // Terminal clock of the current prescaler cycle.
    always_comb begin
        tc = (cnt == '0);
    end

    // Down counter with modulus chosen at each reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RST_HI ? LD_HI : LD_LO;
        end else if (tc) begin
            cnt <= mod_hi ? LD_HI : LD_LO;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sdp_swallow_div.sv
`timescale 1ns/1ps
// sdp_swallow_div: main divider, N = PRESC*B + A. The first A prescaler
// cycles of a period run at PRESC+1 and the remaining B-A at PRESC. At the
// end of the B-th prescaler cycle a one-clock pulse is issued and the next
// setting is loaded: the input setting when legal, otherwise the last legal.
// Assumes: DEF_A/DEF_B form a legal setting; cfg_in is synchronous to clk.
module sdp_swallow_div
    import sdp_pkg::*;
#(
    parameter int PRESC = 16,
    parameter int DEF_A = 9,
    parameter int DEF_B = 54
) (
    input  logic      clk,
    input  logic      rst_n,
    input  main_cfg_t cfg_in,
    output logic      pulse,
    output logic      cfg_err
);
    localparam logic [A_W-1:0] A0 = A_W'(DEF_A);
    localparam logic [B_W-1:0] B0 = B_W'(DEF_B);

    main_cfg_t      act;
    main_cfg_t      nxt;
    logic           ok;
    logic           tc;
    logic           last;
    logic           mod_hi;
    logic [A_W-1:0] a_left;
    logic [A_W-1:0] a_next;
    logic [B_W-1:0] b_left;

    sdp_cfg_check #(.PRESC(PRESC)) u_check (
        .cfg (cfg_in),
        .ok  (ok)
    );

    sdp_dual_mod_presc #(.PRESC(PRESC), .RST_HI(DEF_A != 0)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .mod_hi (mod_hi),
        .tc     (tc)
    );

    // Next setting, terminal detection and modulus for the next prescaler cycle.
    always_comb begin
        nxt  = ok ? cfg_in : act;
        last = tc && (b_left == B_W'(1));
        if (last) begin
            a_next = nxt.a;
        end else if (tc && (a_left != '0)) begin
            a_next = a_left - 1'b1;
        end else begin
            a_next = a_left;
        end
        mod_hi = (a_next != '0);
    end

    // Swallow/program counters, held setting, output pulse and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= '{b: B0, a: A0};
            a_left  <= A0;
            b_left  <= B0;
            pulse   <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            a_left  <= a_next;
            cfg_err <= !ok;
            pulse   <= last;
            if (last) begin
                b_left <= nxt.b;
                act    <= nxt;
            end else if (tc) begin
                b_left <= b_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdp_ref_div.sv
`timescale 1ns/1ps
// sdp_ref_div: reference divider. Counts R clocks per period, issues a
// one-clock pulse at the terminal count and loads the next ratio there: the
// input when R >= 2, otherwise the last legal ratio.
// Assumes: DEF_R is legal; r_in is synchronous to clk.
module sdp_ref_div
    import sdp_pkg::*;
#(
    parameter int R_W   = 10,
    parameter int DEF_R = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_in,
    output logic           pulse,
    output logic           cfg_err
);
    localparam logic [R_W-1:0] R0    = R_W'(DEF_R);
    localparam logic [R_W-1:0] R_MIN = R_W'(MIN_DIV);

    logic [R_W-1:0] cnt;
    logic [R_W-1:0] act;
    logic [R_W-1:0] nxt;
    logic           ok;
    logic           tc;

    // Range check, next ratio and terminal count.
    always_comb begin
        ok  = (r_in >= R_MIN);
        nxt = ok ? r_in : act;
        tc  = (cnt == '0);
    end

    // Down counter, held ratio, pulse and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= R0 - 1'b1;
            act     <= R0;
            pulse   <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !ok;
            pulse   <= tc;
            if (tc) begin
                cnt <= nxt - 1'b1;
                act <= nxt;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/synth_div_pair.sv
`timescale 1ns/1ps
// synth_div_pair: reference and main dividers of an integer-N synthesizer.
// The reference side runs on clk_ref, the main side on clk_vco.
// Assumes: PRESC is 16 or 64; rst_n is already synchronised to both clocks;
// the setting inputs are steady levels from a register bank.
module synth_div_pair
    import sdp_pkg::*;
#(
    parameter int PRESC = 16,
    parameter int R_W   = (PRESC == 64) ? 12 : 10,
    parameter int DEF_R = 8,
    parameter int DEF_A = 9,
    parameter int DEF_B = 54
) (
    input  logic           clk_ref,
    input  logic           clk_vco,
    input  logic           rst_n,
    input  logic [R_W-1:0] ref_div_val,
    input  logic [A_W-1:0] swallow_val,
    input  logic [B_W-1:0] program_val,
    output logic           ref_pulse,
    output logic           ref_cfg_err,
    output logic           vco_pulse,
    output logic           vco_cfg_err
);
    main_cfg_t main_cfg;

    // Bundle the main setting for the swallow divider.
    always_comb begin
        main_cfg = '{b: program_val, a: swallow_val};
    end

    sdp_ref_div #(.R_W(R_W), .DEF_R(DEF_R)) u_ref (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .r_in    (ref_div_val),
        .pulse   (ref_pulse),
        .cfg_err (ref_cfg_err)
    );

    sdp_swallow_div #(.PRESC(PRESC), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_main (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .cfg_in  (main_cfg),
        .pulse   (vco_pulse),
        .cfg_err (vco_cfg_err)
    );
endmodule

// File: rtl/synth_div_pair_chk.sv
`timescale 1ns/1ps
// synth_div_pair_chk: temporal properties of the divider pair, bound to
// every instance of synth_div_pair.
module synth_div_pair_chk
    import sdp_pkg::*;
#(
    parameter int PRESC = 16,
    parameter int R_W   = 10
) (
    input logic           clk_ref,
    input logic           clk_vco,
    input logic           rst_n,
    input logic [R_W-1:0] ref_div_val,
    input logic [A_W-1:0] swallow_val,
    input logic [B_W-1:0] program_val,
    input logic           ref_pulse,
    input logic           ref_cfg_err,
    input logic           vco_pulse,
    input logic           vco_cfg_err
);
    localparam int               GAP_W   = 16;
    localparam logic [GAP_W-1:0] MIN_GAP = GAP_W'(2 * PRESC);
    localparam logic [A_W-1:0]   A_MAX   = A_W'(PRESC - 2);

    logic [GAP_W-1:0] gap;
    logic             seen;
    logic             ab_ok;

    // Legality of the main inputs, judged from the requirement text.
    always_comb begin
        ab_ok = (program_val >= B_W'(2)) && (B_W'(swallow_val) < program_val)
                && (swallow_val <= A_MAX);
    end

    // Saturating count of VCO clocks since the previous main pulse.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (vco_pulse) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    p_vco_pulse_one_r3: assert property (@(posedge clk_vco) disable iff (!rst_n)
        vco_pulse |=> !vco_pulse);

    p_ref_pulse_one_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    p_min_gap_r1: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (vco_pulse && seen) |-> (gap >= MIN_GAP));

    p_b_low_err_r4: assert property (@(posedge clk_vco) disable iff (!rst_n)
        ($past(rst_n) && $past(program_val < B_W'(2))) |-> vco_cfg_err);

    p_ab_err_r5: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $past(rst_n) |-> (vco_cfg_err == $past(!ab_ok)));

    p_r_low_err_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(rst_n) && $past(ref_div_val < R_W'(2))) |-> ref_cfg_err);

    p_reset_quiet_r8: assert property (@(posedge clk_vco)
        !rst_n |=> (!vco_pulse && !vco_cfg_err));
endmodule

bind synth_div_pair synth_div_pair_chk #(.PRESC(PRESC), .R_W(R_W)) u_chk (
    .clk_ref     (clk_ref),
    .clk_vco     (clk_vco),
    .rst_n       (rst_n),
    .ref_div_val (ref_div_val),
    .swallow_val (swallow_val),
    .program_val (program_val),
    .ref_pulse   (ref_pulse),
    .ref_cfg_err (ref_cfg_err),
    .vco_pulse   (vco_pulse),
    .vco_cfg_err (vco_cfg_err)
);

// File: tb/synth_div_pair_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random settings; pulse spacing is
// measured at the falling edge of each clock and compared with bench models.
module synth_div_pair_bench;
    localparam int P = 16;

    logic        clk_ref = 1'b0;
    logic        clk_vco = 1'b0;
    logic        rst_n   = 1'b0;
    logic [9:0]  r_val;
    logic [6:0]  a_val;
    logic [10:0] b_val;
    logic        ref_pulse, ref_err, vco_pulse, vco_err;
    logic        ref64_pulse, ref64_err, vco64_pulse, vco64_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk_ref = ~clk_ref;   // 200 MHz
    always #1.0 clk_vco = ~clk_vco;

    synth_div_pair u_synth_div_pair (
        .clk_ref(clk_ref), .clk_vco(clk_vco), .rst_n(rst_n),
        .ref_div_val(r_val), .swallow_val(a_val), .program_val(b_val),
        .ref_pulse(ref_pulse), .ref_cfg_err(ref_err),
        .vco_pulse(vco_pulse), .vco_cfg_err(vco_err)
    );

    synth_div_pair #(.PRESC(64), .DEF_R(256), .DEF_A(16), .DEF_B(411)) u_synth_div_pair_p64 (
        .clk_ref(clk_ref), .clk_vco(clk_vco), .rst_n(rst_n),
        .ref_div_val(12'd256), .swallow_val(7'd16), .program_val(11'd411),
        .ref_pulse(ref64_pulse), .ref_cfg_err(ref64_err),
        .vco_pulse(vco64_pulse), .vco_cfg_err(vco64_err)
    );

    // Pulse monitors: period in clocks between consecutive pulses.
    int  v_cyc = 0, v_last = 0, v_per = 0, v_cnt = 0;
    int  r_cyc = 0, r_last = 0, r_per = 0, r_cnt = 0;
    int  v64_cyc = 0, v64_last = 0, v64_per = 0, v64_cnt = 0;
    int  r64_cyc = 0, r64_last = 0, r64_per = 0;
    bit  v_prev = 0, r_prev = 0, wide_seen = 0;

    always @(negedge clk_vco) begin
        v_cyc++;
        v64_cyc++;
        if (vco_pulse) begin
            v_per = v_cyc - v_last; v_last = v_cyc; v_cnt++;
        end
        if (vco64_pulse) begin
            v64_per = v64_cyc - v64_last; v64_last = v64_cyc; v64_cnt++;
        end
        if (vco_pulse && v_prev) wide_seen = 1;
        v_prev = vco_pulse;
    end

    always @(negedge clk_ref) begin
        r_cyc++;
        r64_cyc++;
        if (ref_pulse) begin
            r_per = r_cyc - r_last; r_last = r_cyc; r_cnt++;
        end
        if (ref64_pulse) begin
            r64_per = r64_cyc - r64_last; r64_last = r64_cyc;
        end
        if (ref_pulse && r_prev) wide_seen = 1;
        r_prev = ref_pulse;
    end

    function automatic int n_of(int a, int b);
        return P * b + a;
    endfunction

    function automatic bit ab_legal(int a, int b);
        return (b >= 2) && (b <= 2047) && (a < b) && (a <= P - 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic vco_wait(input int k);
        int t = v_cnt + k;
        wait (v_cnt >= t);
        @(negedge clk_vco);
    endtask

    task automatic ref_wait(input int k);
        int t = r_cnt + k;
        wait (r_cnt >= t);
        @(negedge clk_ref);
    endtask

    task automatic set_main(input int a, input int b);
        @(negedge clk_vco);
        a_val = 7'(a);
        b_val = 11'(b);
    endtask

    task automatic set_r(input int r);
        @(negedge clk_ref);
        r_val = 10'(r);
    endtask

    // Main-side check: the next period equals exp_n, error flag equals exp_e.
    task automatic main_step(input int a, input int b, input int exp_n, input bit exp_e, input string req);
        set_main(a, b);
        repeat (3) @(negedge clk_vco);
        check(vco_err == exp_e, req, int'(vco_err), int'(exp_e));
        vco_wait(2);
        check(v_per == exp_n, req, v_per, exp_n);
    endtask

    task automatic ref_step(input int r, input int exp_r, input bit exp_e, input string req);
        set_r(r);
        repeat (3) @(negedge clk_ref);
        check(ref_err == exp_e, req, int'(ref_err), int'(exp_e));
        ref_wait(2);
        check(r_per == exp_r, req, r_per, exp_r);
    endtask

    initial begin
        int exp_n;
        int exp_r;
        void'($urandom(32'h5EED_1234));
        a_val = '0; b_val = '0; r_val = '0;   // illegal inputs across reset
        rst_n = 1'b0;
        repeat (5) @(negedge clk_ref);
        // R8: quiet outputs in reset
        check({vco_pulse, vco_err, ref_pulse, ref_err} == 4'b0, "R8",
              int'({vco_pulse, vco_err, ref_pulse, ref_err}), 0);
        #1.5 rst_n = 1'b1;

        // R8: defaults in use after release, inputs illegal so flags set (R4, R6)
        vco_wait(3);
        check(v_per == 873, "R8", v_per, 873);
        check(vco_err == 1'b1, "R4", int'(vco_err), 1);
        ref_wait(3);
        check(r_per == 8, "R8", r_per, 8);
        check(ref_err == 1'b1, "R6", int'(ref_err), 1);

        // R7: change early in a period; the period in progress keeps the old ratio
        vco_wait(1);
        set_main(3, 20);
        vco_wait(1);
        check(v_per == 873, "R7", v_per, 873);
        vco_wait(1);
        check(v_per == n_of(3, 20), "R1", v_per, n_of(3, 20));
        ref_wait(1);
        set_r(50);
        ref_wait(1);
        check(r_per == 8, "R7", r_per, 8);
        ref_wait(1);
        check(r_per == 50, "R2", r_per, 50);

        // R9: extreme legal settings
        main_step(P - 2, 15, n_of(P - 2, 15), 1'b0, "R9");
        main_step(0, 2, n_of(0, 2), 1'b0, "R9");
        main_step(0, 2047, n_of(0, 2047), 1'b0, "R9");
        ref_step(1023, 1023, 1'b0, "R9");
        ref_step(2, 2, 1'b0, "R9");

        // R5 / R4: illegal main settings hold the last legal period
        main_step(5, 30, n_of(5, 30), 1'b0, "R1");
        main_step(P - 1, 30, n_of(5, 30), 1'b1, "R5");
        main_step(30, 30, n_of(5, 30), 1'b1, "R5");
        main_step(0, 1, n_of(5, 30), 1'b1, "R4");
        main_step(2, 10, n_of(2, 10), 1'b0, "R5");

        // R6: illegal reference ratios hold
        ref_step(1, 2, 1'b1, "R6");
        ref_step(0, 2, 1'b1, "R6");
        ref_step(37, 37, 1'b0, "R2");

        // Random mix of legal and illegal settings (R1, R5)
        exp_n = n_of(2, 10);
        for (int i = 0; i < 16; i++) begin
            int a;
            int b;
            bit ok;
            a = int'($urandom % 15);
            b = a + 1 + int'($urandom % 40);
            if (b < 2) b = 2;
            if (($urandom % 4) == 0) a = b + int'($urandom % 3);
            ok = ab_legal(a, b);
            if (ok) exp_n = n_of(a, b);
            main_step(a, b, exp_n, !ok, ok ? "R1" : "R5");
        end

        // Random reference ratios (R2, R6)
        exp_r = 37;
        for (int i = 0; i < 12; i++) begin
            int r;
            r = 2 + int'($urandom % 200);
            if (($urandom % 4) == 0) r = int'($urandom % 2);
            if (r >= 2) exp_r = r;
            ref_step(r, exp_r, r < 2, r >= 2 ? "R2" : "R6");
        end

        // R10: modulus-64 instance
        wait (v64_cnt >= 2);
        @(negedge clk_vco);
        check(v64_per == 26320, "R10", v64_per, 26320);
        check(r64_per == 256, "R10", r64_per, 256);
        check({vco64_err, ref64_err} == 2'b0, "R10", int'({vco64_err, ref64_err}), 0);

        // R3: no pulse ever lasted two clocks
        check(!wide_seen, "R3", int'(wide_seen), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule